// File: doc/BRIEF.md
# Snoop Receive Buffer with Reserved Reply Entry

This block sits between a split-transaction snooping bus and a cache controller. While the local processor has a miss in flight, other agents keep placing requests and replies on the bus, and the controller cannot always service them at once. The buffer takes these transactions so that the bus never has to stall for this cache. It stores them until the controller pulls them from a dequeue port.

Storage is split into a pool of shared entries and one extra entry that only a reply may occupy. The default pool size is one entry per processor. A request that finds the shared pool full is refused with a negative acknowledgement. Each refused requester ID is then flagged toward the bus arbiter, so it gets raised priority until its retry lands. A reply is never refused for lack of shared space: it uses the reserved entry. Replies sitting in the reserved entry leave before any queued request.

The block also gates the controller's own bus requests. A new local request may not be issued while this cache still owes a response on the bus.

Top module: `snp_req_buf`

## Requirements
- R1: After reset the buffer is empty (`deq_valid` low), `prio_mask` is all zero, and a request presented on the bus side sees `in_ready` high.
- R2: A request (`in_is_reply`=0) arriving while the shared pool has a free entry is accepted (`in_ready`=1, `in_nack`=0) in the same cycle it is presented.
- R3: A request arriving while all SHARED_SLOTS shared entries are occupied sees `in_ready`=0 and `in_nack`=1, and it is not stored.
- R4: A reply (`in_is_reply`=1) arriving while the reserved reply entry is empty is accepted even when the shared pool is full. `in_nack` stays 0.
- R5: `in_nack` is never asserted for a reply. A reply arriving when both the reserved entry and the shared pool are full sees `in_ready`=0 and `in_nack`=0.
- R6: While the reserved reply entry is occupied, the dequeue port presents that reply ahead of everything in the shared pool. Otherwise shared entries leave in arrival order.
- R7: Bit k of `prio_mask` goes high in the cycle after a request from source k is refused. It stays high until the cycle after a request from source k is accepted. `prio_any` is the OR of the mask.
- R8: `loc_req_go` is high only when `loc_req_want` is high and `loc_resp_owed` is low.
- R9: A reply arriving while the reserved entry is occupied and the shared pool has room is accepted into the shared pool. It then leaves in arrival order with the requests there.
- R10: An accept and a dequeue in the same cycle are both carried out. The contents stay consistent, with no entry lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bus-side transaction present |
| in_is_reply | input | 1 | 1 = reply, 0 = request |
| in_src_id | input | ID_W | Source agent ID |
| in_payload | input | PAY_W | Transaction payload |
| in_ready | output | 1 | Transaction would be taken this cycle |
| in_nack | output | 1 | Presented request is refused |
| deq_valid | output | 1 | Entry available to the controller |
| deq_is_reply | output | 1 | Head entry is a reply |
| deq_src_id | output | ID_W | Head entry source ID |
| deq_payload | output | PAY_W | Head entry payload |
| deq_ready | input | 1 | Controller takes the head entry |
| prio_mask | output | NUM_PROCS | Per-source raised-priority flags to the arbiter |
| prio_any | output | 1 | Any priority flag set |
| loc_req_want | input | 1 | Controller wants to issue a new request |
| loc_resp_owed | input | 1 | This cache owes a response on the bus |
| loc_req_go | output | 1 | New local request may go to the arbiter |

## Verification
The bench builds the block with NUM_PROCS=4 and SHARED_SLOTS=2, which is below the one-per-processor bound. With only two shared entries, refusals, the full-pool reply path and both-full back-pressure are all reachable within a few transfers. The four-source mask still lets the bench check that a refusal flags exactly one bit. PAY_W=8 keeps the payload tags distinct, so the bench can confirm bypass and arrival order.

// File: rtl/snp_pkg.sv
package snp_pkg;

  // Whether an arriving transaction can be stored this cycle.
  function automatic logic take_ok(input logic is_reply,
                                   input logic pool_full,
                                   input logic slot_full);
    return is_reply ? (!slot_full || !pool_full) : !pool_full;
  endfunction

  // Replies go to the reserved entry whenever it is free.
  function automatic logic goes_to_slot(input logic is_reply,
                                        input logic slot_full);
    return is_reply && !slot_full;
  endfunction

  // Only requests are ever refused.
  function automatic logic refuse(input logic is_reply,
                                  input logic pool_full);
    return !is_reply && pool_full;
  endfunction

endpackage

// File: rtl/snp_fifo.sv
module snp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/snp_reply_slot.sv
module snp_reply_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             unload,
  output logic             full,
  output logic [WIDTH-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (unload) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/snp_nack_trk.sv
module snp_nack_trk #(
  parameter int NUM_PROCS = 4,
  parameter int ID_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nack_fire,
  input  logic                 req_take,
  input  logic [ID_W-1:0]      src_id,
  output logic [NUM_PROCS-1:0] mask
);
  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_src
    logic hit;
    assign hit = (src_id == ID_W'(p));
    always_ff @(posedge clk) begin
      if (!rst_n)                mask[p] <= 1'b0;
      else if (nack_fire && hit) mask[p] <= 1'b1;
      else if (req_take && hit)  mask[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/snp_req_buf.sv
module snp_req_buf
  import snp_pkg::*;
#(
  parameter int NUM_PROCS    = 4,
  parameter int SHARED_SLOTS = NUM_PROCS,
  parameter int PAY_W        = 16,
  localparam int ID_W  = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int ENT_W = 1 + ID_W + PAY_W,
  localparam int CNT_W = $clog2(SHARED_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_is_reply,
  input  logic [ID_W-1:0]      in_src_id,
  input  logic [PAY_W-1:0]     in_payload,
  output logic                 in_ready,
  output logic                 in_nack,
  output logic                 deq_valid,
  output logic                 deq_is_reply,
  output logic [ID_W-1:0]      deq_src_id,
  output logic [PAY_W-1:0]     deq_payload,
  input  logic                 deq_ready,
  output logic [NUM_PROCS-1:0] prio_mask,
  output logic                 prio_any,
  input  logic                 loc_req_want,
  input  logic                 loc_resp_owed,
  output logic                 loc_req_go
);
  // Internal event wires, named for the checker.
  logic             ev_accept, ev_nack, ev_slot_load, ev_pool_push, ev_deq;
  logic             pool_full, pool_empty, slot_full;
  logic [CNT_W-1:0] pool_cnt;
  logic [ENT_W-1:0] in_ent, pool_head, slot_data, head_ent;

  assign in_ent = {in_is_reply, in_src_id, in_payload};

  // Bus-side decision, from registered occupancy only.
  assign in_ready     = take_ok(in_is_reply, pool_full, slot_full);
  assign ev_nack      = in_valid && refuse(in_is_reply, pool_full);
  assign in_nack      = ev_nack;
  assign ev_accept    = in_valid && in_ready;
  assign ev_slot_load = ev_accept && goes_to_slot(in_is_reply, slot_full);
  assign ev_pool_push = ev_accept && !ev_slot_load;

  // Dequeue side: the reserved reply bypasses the pool.
  assign deq_valid = slot_full || !pool_empty;
  assign ev_deq    = deq_valid && deq_ready;
  assign head_ent  = slot_full ? slot_data : pool_head;
  assign {deq_is_reply, deq_src_id, deq_payload} = head_ent;

  snp_fifo #(.WIDTH(ENT_W), .DEPTH(SHARED_SLOTS)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_pool_push),
    .push_data (in_ent),
    .pop       (ev_deq && !slot_full),
    .head      (pool_head),
    .empty     (pool_empty),
    .full      (pool_full),
    .count     (pool_cnt)
  );

  snp_reply_slot #(.WIDTH(ENT_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_slot_load),
    .load_data (in_ent),
    .unload    (ev_deq && slot_full),
    .full      (slot_full),
    .data      (slot_data)
  );

  snp_nack_trk #(.NUM_PROCS(NUM_PROCS), .ID_W(ID_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nack_fire (ev_nack),
    .req_take  (ev_accept && !in_is_reply),
    .src_id    (in_src_id),
    .mask      (prio_mask)
  );

  assign prio_any = |prio_mask;

  // A response this cache owes wins over any new local request.
  assign loc_req_go = loc_req_want && !loc_resp_owed;
endmodule

// File: rtl/snp_req_buf_chk.sv
module snp_req_buf_chk #(
  parameter int CNT_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_is_reply,
  input logic             in_ready,
  input logic             in_nack,
  input logic             slot_full,
  input logic [CNT_W-1:0] pool_cnt,
  input logic             deq_valid,
  input logic             deq_is_reply,
  input logic             prio_any,
  input logic             ev_accept,
  input logic             loc_resp_owed,
  input logic             loc_req_go
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pool_cnt <= CNT_W'(DEPTH)); // R3
  AST_NACK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_nack |-> !in_ready); // R3
  AST_REPLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_reply && !slot_full) |-> (in_ready && !in_nack)); // R4
  AST_BYPASS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !deq_is_reply) |-> !slot_full); // R6
  AST_PRIO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_nack |=> prio_any); // R7
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_any && !ev_accept) |=> prio_any); // R7
  AST_RESP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    loc_resp_owed |-> !loc_req_go); // R8
endmodule

bind snp_req_buf snp_req_buf_chk #(.CNT_W(CNT_W), .DEPTH(SHARED_SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_is_reply   (in_is_reply),
  .in_ready      (in_ready),
  .in_nack       (in_nack),
  .slot_full     (slot_full),
  .pool_cnt      (pool_cnt),
  .deq_valid     (deq_valid),
  .deq_is_reply  (deq_is_reply),
  .prio_any      (prio_any),
  .ev_accept     (ev_accept),
  .loc_resp_owed (loc_resp_owed),
  .loc_req_go    (loc_req_go)
);

// File: tb/snp_req_buf_tb.sv
module snp_req_buf_tb;
  localparam int NP = 4;
  localparam int SS = 2;
  localparam int PW = 8;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_is_reply = 0, deq_ready = 0;
  logic [IW-1:0] in_src_id = '0;
  logic [PW-1:0] in_payload = '0;
  logic loc_req_want = 0, loc_resp_owed = 0;
  logic in_ready, in_nack, deq_valid, deq_is_reply, prio_any, loc_req_go;
  logic [IW-1:0] deq_src_id;
  logic [PW-1:0] deq_payload;
  logic [NP-1:0] prio_mask;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  snp_req_buf #(.NUM_PROCS(NP), .SHARED_SLOTS(SS), .PAY_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_reply(in_is_reply),
    .in_src_id(in_src_id), .in_payload(in_payload), .in_ready(in_ready),
    .in_nack(in_nack), .deq_valid(deq_valid), .deq_is_reply(deq_is_reply),
    .deq_src_id(deq_src_id), .deq_payload(deq_payload), .deq_ready(deq_ready),
    .prio_mask(prio_mask), .prio_any(prio_any), .loc_req_want(loc_req_want),
    .loc_resp_owed(loc_resp_owed), .loc_req_go(loc_req_go));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one transaction for one cycle and check the same-cycle response.
  task automatic offer(input bit rep, input int id, input int pay,
                       input bit exp_rdy, input bit exp_nack, input string req);
    @(negedge clk);
    in_valid = 1; in_is_reply = rep; in_src_id = IW'(id); in_payload = PW'(pay);
    #2;
    chk(req, int'(in_ready), int'(exp_rdy));
    chk(req, int'(in_nack), int'(exp_nack));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // Take the head entry and check its contents.
  task automatic take(input bit exp_rep, input int exp_pay, input string req);
    @(negedge clk);
    deq_ready = 1;
    #2;
    chk(req, int'(deq_valid), 1);
    chk(req, int'(deq_is_reply), int'(exp_rep));
    chk(req, int'(deq_payload), exp_pay);
    @(posedge clk); #1;
    deq_ready = 0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk); #2;
    chk(req, int'(deq_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    in_is_reply = 0; #2;
    chk("R1 deq_valid", int'(deq_valid), 0);
    chk("R1 prio_mask", int'(prio_mask), 0);
    chk("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_pool_order();
    offer(0, 1, 8'hA1, 1, 0, "R2 first");
    offer(0, 2, 8'hA2, 1, 0, "R2 second");
    take(0, 8'hA1, "R6 order a");
    take(0, 8'hA2, "R6 order b");
    expect_empty("R6 drained");
  endtask

  task automatic t_nack_bypass();
    offer(0, 0, 8'h10, 1, 0, "R2 fill0");
    offer(0, 1, 8'h11, 1, 0, "R2 fill1");
    offer(0, 3, 8'h13, 0, 1, "R3 refused");
    @(negedge clk); #2;
    chk("R7 raised", int'(prio_mask), 4'b1000);
    chk("R7 any", int'(prio_any), 1);
    offer(1, 2, 8'hE2, 1, 0, "R4 reply full pool");
    offer(1, 0, 8'hE0, 0, 0, "R5 both full");
    take(1, 8'hE2, "R6 bypass");
    take(0, 8'h10, "R6 after bypass a");
    chk("R3 not stored", int'(deq_valid), 1);
    take(0, 8'h11, "R6 after bypass b");
    expect_empty("R3 refused not stored");
    chk("R7 held", int'(prio_mask), 4'b1000);
    offer(0, 3, 8'h13, 1, 0, "R7 retry taken");
    @(negedge clk); #2;
    chk("R7 cleared", int'(prio_mask), 0);
    take(0, 8'h13, "R7 retry stored");
  endtask

  task automatic t_reply_in_pool();
    offer(1, 0, 8'hB0, 1, 0, "R4 to slot");
    offer(1, 1, 8'hB1, 1, 0, "R9 to pool");
    offer(0, 2, 8'hB2, 1, 0, "R9 req after");
    take(1, 8'hB0, "R9 slot first");
    take(1, 8'hB1, "R9 pool reply");
    take(0, 8'hB2, "R9 pool req");
    expect_empty("R9 drained");
  endtask

  task automatic t_simul();
    offer(0, 1, 8'hC1, 1, 0, "R10 prime");
    @(negedge clk);
    in_valid = 1; in_is_reply = 0; in_src_id = 2; in_payload = 8'hC2;
    deq_ready = 1; #2;
    chk("R10 head", int'(deq_payload), 8'hC1);
    chk("R10 ready", int'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 0; deq_ready = 0;
    take(0, 8'hC2, "R10 second");
    expect_empty("R10 count");
  endtask

  task automatic t_gate();
    @(negedge clk);
    loc_req_want = 1; loc_resp_owed = 1; #2;
    chk("R8 blocked", int'(loc_req_go), 0);
    @(negedge clk);
    loc_resp_owed = 0; #2;
    chk("R8 allowed", int'(loc_req_go), 1);
    @(negedge clk);
    loc_req_want = 0; #2;
    chk("R8 idle", int'(loc_req_go), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_pool_order();
    t_nack_bypass();
    t_reply_in_pool();
    t_simul();
    t_gate();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule